// File: doc/BRIEF.md
# Mailbox Bridge to Byte-Wide Peripherals

This block lets a host with a 32-bit register port reach two byte-wide peripherals through one command word. The host writes the word. The word names the target device and the register inside it (address latch or data port). It also gives the direction and, for a write, the byte to send. The bridge then runs one timed access on a narrow local bus. While that access runs, it shows a pending flag in the same word.

Each peripheral register access takes two commands. The first writes the register offset into the chosen device's address latch. The second reads or writes that device's data port. Software polls the pending bit after each command. After a read, software takes the returned byte from the low byte of the word.

On device 1, the second sub-channel is reached by adding 0x40 to the offset. Its FIFO is therefore at offset 0x5F, while the first sub-channel's FIFO is at 0x1F. Device 0's FIFO is at offset 0x1E.

Top module: `pob_bridge`

## Requirements
- R1: After reset the readback word is all zeros, both strobes are low and no chip select is active.
- R2: A command write taken while pending is clear makes bit 25 (pending) read 1 from the very next cycle.
- R3: A strobe is held for exactly STROBE_CYCLES cycles. Bit 23 = 1 gives a write strobe (lb_wr) and bit 23 = 0 gives a read strobe (lb_rd). The two strobes are never high together.
- R4: Bit 20 picks the chip select: 0 drives lb_cs[0] and 1 drives lb_cs[1]. At most one select is high, and a select is high exactly while a strobe is.
- R5: During a strobe, lb_ads equals bit 16 (0 = address latch, 1 = data port) and lb_wdata equals bits 7:0. Both hold steady for the whole strobe.
- R6: Pending clears one cycle after the strobe is released.
- R7: For a read, the byte on lb_rdata in the last strobe cycle is captured and shows in bits 7:0 of the readback word. For a write, bits 7:0 keep the byte that was written.
- R8: A command write while pending is set is ignored: the running access and the stored fields are unchanged. Bit 31 (error) is set and stays set until reset.
- R9: Bits 23, 20 and 16 of the readback word mirror the last accepted command. Every bit outside 31, 25, 23, 20, 16 and 7:0 reads 0.
- R10: A command written in the first cycle that pending reads 0 is accepted and starts a new access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for the command word |
| host_wdata | input | 32 | Command word from the host |
| host_rdata | output | 32 | Readback word: error, pending, fields, data byte |
| lb_cs | output | 2 | Chip selects, one per device |
| lb_ads | output | 1 | Register select: 0 address latch, 1 data port |
| lb_rd | output | 1 | Read strobe |
| lb_wr | output | 1 | Write strobe |
| lb_wdata | output | 8 | Byte driven to the peripheral |
| lb_rdata | input | 8 | Byte returned by the peripheral |

## Verification
An accepted command raises pending and starts the select and strobe one cycle after the write edge. The strobe lasts STROBE_CYCLES cycles. Pending drops, and read data appears, one cycle after the strobe ends. An error caused by a write during pending shows on the cycle after that write. The bench keeps a behavioural model that advances on each rising edge. It compares every output on the following falling edge, so every expected value is taken at exactly the cycle in which it becomes due.

// File: rtl/pob_pkg.sv
package pob_pkg;

    // Command word bit positions (software decodes these)
    localparam int unsigned BIT_ERR  = 31;
    localparam int unsigned BIT_PEND = 25;
    localparam int unsigned BIT_WR   = 23;
    localparam int unsigned BIT_DEV  = 20;
    localparam int unsigned BIT_SEL  = 16;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned NUM_DEV  = 2;

    typedef struct packed {
        logic              wr;
        logic              dev;
        logic              sel;
        logic [BYTE_W-1:0] dbyte;
    } pob_cmd_t;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_STROBE  = 2'd1,
        PH_RECOVER = 2'd2
    } pob_phase_e;

    function automatic pob_cmd_t pob_decode(input logic [WORD_W-1:0] w);
        pob_cmd_t c;
        c.wr    = w[BIT_WR];
        c.dev   = w[BIT_DEV];
        c.sel   = w[BIT_SEL];
        c.dbyte = w[BYTE_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pob_pack(input pob_cmd_t c,
                                                   input logic pend,
                                                   input logic err);
        logic [WORD_W-1:0] w;
        w             = '0;
        w[BIT_ERR]    = err;
        w[BIT_PEND]   = pend;
        w[BIT_WR]     = c.wr;
        w[BIT_DEV]    = c.dev;
        w[BIT_SEL]    = c.sel;
        w[BYTE_W-1:0] = c.dbyte;
        return w;
    endfunction

endpackage

// File: rtl/pob_seq.sv
module pob_seq
    import pob_pkg::*;
#(
    parameter int unsigned STROBE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic strobe,
    output logic strobe_end
);
    localparam int unsigned CW = $clog2(STROBE_CYCLES + 1);

    pob_phase_e    phase;
    logic [CW-1:0] cnt;

    assign busy       = (phase != PH_IDLE);
    assign strobe     = (phase == PH_STROBE);
    assign strobe_end = strobe && (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_STROBE;
                        cnt   <= CW'(STROBE_CYCLES);
                    end
                end
                PH_STROBE: begin
                    cnt <= cnt - CW'(1);
                    if (cnt == CW'(1)) phase <= PH_RECOVER;
                end
                PH_RECOVER: phase <= PH_IDLE;
                default:    phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pob_cmd_reg.sv
module pob_cmd_reg
    import pob_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              busy,
    input  logic              strobe_end,
    input  logic [BYTE_W-1:0] rd_byte,
    output pob_cmd_t          cmd,
    output logic              err,
    output logic              accept
);
    assign accept = host_we && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
            err <= 1'b0;
        end else begin
            if (accept) begin
                cmd <= pob_decode(host_wdata);
            end else if (strobe_end && !cmd.wr) begin
                cmd.dbyte <= rd_byte;
            end
            if (host_we && busy) err <= 1'b1;
        end
    end
endmodule

// File: rtl/pob_lbus_drive.sv
module pob_lbus_drive
    import pob_pkg::*;
(
    input  pob_cmd_t           cmd,
    input  logic               strobe,
    output logic [NUM_DEV-1:0] lb_cs,
    output logic               lb_ads,
    output logic               lb_rd,
    output logic               lb_wr,
    output logic [BYTE_W-1:0]  lb_wdata
);
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_cs
        assign lb_cs[d] = strobe && (cmd.dev == 1'(d));
    end

    assign lb_rd    = strobe && !cmd.wr;
    assign lb_wr    = strobe &&  cmd.wr;
    assign lb_ads   = cmd.sel;
    assign lb_wdata = cmd.dbyte;
endmodule

// File: rtl/pob_bridge.sv
module pob_bridge
    import pob_pkg::*;
#(
    parameter int unsigned STROBE_CYCLES = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic [WORD_W-1:0]  host_wdata,
    output logic [WORD_W-1:0]  host_rdata,
    output logic [NUM_DEV-1:0] lb_cs,
    output logic               lb_ads,
    output logic               lb_rd,
    output logic               lb_wr,
    output logic [BYTE_W-1:0]  lb_wdata,
    input  logic [BYTE_W-1:0]  lb_rdata
);
    logic     busy, strobe, strobe_end, accept, err;
    pob_cmd_t cmd;

    pob_cmd_reg u_cmd (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .busy       (busy),
        .strobe_end (strobe_end),
        .rd_byte    (lb_rdata),
        .cmd        (cmd),
        .err        (err),
        .accept     (accept)
    );

    pob_seq #(.STROBE_CYCLES(STROBE_CYCLES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .busy       (busy),
        .strobe     (strobe),
        .strobe_end (strobe_end)
    );

    pob_lbus_drive u_drv (
        .cmd      (cmd),
        .strobe   (strobe),
        .lb_cs    (lb_cs),
        .lb_ads   (lb_ads),
        .lb_rd    (lb_rd),
        .lb_wr    (lb_wr),
        .lb_wdata (lb_wdata)
    );

    assign host_rdata = pob_pack(cmd, busy, err);
endmodule

// File: rtl/pob_bridge_chk.sv
module pob_bridge_chk
    import pob_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               host_we,
    input logic [WORD_W-1:0]  host_rdata,
    input logic [NUM_DEV-1:0] lb_cs,
    input logic               lb_ads,
    input logic               lb_rd,
    input logic               lb_wr,
    input logic [BYTE_W-1:0]  lb_wdata
);
    logic stb, pend, err;
    assign stb  = lb_rd || lb_wr;
    assign pend = host_rdata[BIT_PEND];
    assign err  = host_rdata[BIT_ERR];

    // R3
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(lb_rd && lb_wr));

    // R4
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lb_cs) && ((lb_cs != '0) == stb));

    // R2
    pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (host_we && !pend) |=> pend);

    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stb) |-> pend);

    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stb) |=> !pend);

    // R8
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        (host_we && pend) |=> err);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R5
    lbus_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && $past(stb)) |-> ($stable(lb_ads) && $stable(lb_wdata)));
endmodule

bind pob_bridge pob_bridge_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_rdata (host_rdata),
    .lb_cs      (lb_cs),
    .lb_ads     (lb_ads),
    .lb_rd      (lb_rd),
    .lb_wr      (lb_wr),
    .lb_wdata   (lb_wdata)
);

// File: tb/sim_pob_bridge.sv
module sim_pob_bridge;
    localparam int S = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [1:0]  lb_cs;
    logic        lb_ads, lb_rd, lb_wr;
    logic [7:0]  lb_wdata, lb_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pob_bridge #(.STROBE_CYCLES(S)) u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .lb_cs(lb_cs), .lb_ads(lb_ads),
        .lb_rd(lb_rd), .lb_wr(lb_wr), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata)
    );

    // Peripheral storage, updated only by the reference model
    logic [7:0] mem0 [128];
    logic [7:0] mem1 [128];
    logic [7:0] alat0 = 8'h00;
    logic [7:0] alat1 = 8'h00;

    function automatic logic [7:0] periph_read(input logic dev, input logic ads);
        if (!ads) return dev ? alat1 : alat0;
        return dev ? mem1[alat1[6:0]] : mem0[alat0[6:0]];
    endfunction

    assign lb_rdata = lb_rd ? periph_read(lb_cs[1], lb_ads) : 8'h00;

    // Reference model: phase 0 idle, 1 strobe, 2 recovery
    int         m_ph = 0;
    int         m_cnt = 0;
    logic       m_wr = 0, m_dev = 0, m_sel = 0, m_err = 0;
    logic [7:0] m_byte = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_wr = 0; m_dev = 0; m_sel = 0;
            m_err = 0; m_byte = 0;
        end else begin
            case (m_ph)
                0: if (host_we) begin
                    m_wr = host_wdata[23]; m_dev = host_wdata[20];
                    m_sel = host_wdata[16]; m_byte = host_wdata[7:0];
                    m_ph = 1; m_cnt = S;
                end
                1: begin
                    if (host_we) m_err = 1;
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) begin
                        if (m_wr) begin
                            if (!m_sel) begin
                                if (m_dev) alat1 = m_byte; else alat0 = m_byte;
                            end else begin
                                if (m_dev) mem1[alat1[6:0]] = m_byte;
                                else       mem0[alat0[6:0]] = m_byte;
                            end
                        end else begin
                            m_byte = periph_read(m_dev, m_sel);
                        end
                        m_ph = 2;
                    end
                end
                default: begin
                    if (host_we) m_err = 1;
                    m_ph = 0;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            logic [31:0] ew;
            ew = '0;
            ew[31] = m_err; ew[25] = (m_ph != 0); ew[23] = m_wr;
            ew[20] = m_dev; ew[16] = m_sel; ew[7:0] = m_byte;
            chk("R2/R6 pending", 32'(host_rdata[25]), 32'(ew[25]));
            chk("R8 error", 32'(host_rdata[31]), 32'(ew[31]));
            chk("R7 data byte", 32'(host_rdata[7:0]), 32'(ew[7:0]));
            chk("R9 word", host_rdata, ew);
            chk("R4 selects", 32'(lb_cs),
                32'((m_ph == 1) ? (m_dev ? 2'b10 : 2'b01) : 2'b00));
            chk("R3 strobes", 32'({lb_rd, lb_wr}),
                32'((m_ph == 1) ? (m_wr ? 2'b01 : 2'b10) : 2'b00));
            if (m_ph == 1) begin
                chk("R5 ads", 32'(lb_ads), 32'(m_sel));
                if (m_wr) chk("R5 wdata", 32'(lb_wdata), 32'(m_byte));
            end
        end
    end

    task automatic issue(input logic [31:0] c);
        host_we = 1'b1;
        host_wdata = c;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (host_rdata[25]) @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input logic wr, input logic dev,
                                       input logic sel, input logic [7:0] b);
        logic [31:0] w;
        w = '0; w[23] = wr; w[20] = dev; w[16] = sel; w[7:0] = b;
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem0[i] = 8'(i * 3 + 1);
            mem1[i] = 8'(i * 5 + 7);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 rdata", host_rdata, 32'h0);
        chk("R1 strobes/selects", 32'({lb_rd, lb_wr, lb_cs}), 32'h0);

        // Device 0: address then data write, then read back
        issue(mk(1, 0, 0, 8'h1E));
        chk("R2 pending next cycle", 32'(host_rdata[25]), 32'h1);
        wait_idle();
        issue(mk(1, 0, 1, 8'hA5)); wait_idle();
        issue(mk(1, 0, 0, 8'h1E)); wait_idle();
        issue(mk(0, 0, 1, 8'h00)); wait_idle();
        chk("R7 read dev0", 32'(host_rdata[7:0]), 32'hA5);

        // Device 1, both sub-channel FIFOs
        issue(mk(1, 1, 0, 8'h5F)); wait_idle();
        issue(mk(1, 1, 1, 8'h3C)); wait_idle();
        issue(mk(1, 1, 0, 8'h1F)); wait_idle();
        issue(mk(1, 1, 1, 8'hC3)); wait_idle();
        chk("R7 write keeps byte", 32'(host_rdata[7:0]), 32'hC3);
        issue(mk(1, 1, 0, 8'h5F)); wait_idle();
        issue(mk(0, 1, 1, 8'h00)); wait_idle();
        chk("R7 read dev1 ch2", 32'(host_rdata[7:0]), 32'h3C);
        chk("R9 fields", host_rdata & 32'h0091_0000, 32'h0011_0000);

        // Read of the address latch itself
        issue(mk(0, 1, 0, 8'h00)); wait_idle();
        chk("R7 latch read", 32'(host_rdata[7:0]), 32'h5F);

        // R8 collision: second write lands while pending
        chk("R8 err clear before", 32'(host_rdata[31]), 32'h0);
        issue(mk(1, 0, 0, 8'h10));
        issue(mk(0, 1, 1, 8'hEE));
        wait_idle();
        chk("R8 err set", 32'(host_rdata[31]), 32'h1);
        chk("R8 fields kept", host_rdata & 32'h0091_00FF, 32'h0080_0010);
        issue(mk(1, 0, 1, 8'h77)); wait_idle();
        chk("R8 err sticky", 32'(host_rdata[31]), 32'h1);

        // R10 back-to-back: issue on the first idle cycle
        issue(mk(1, 1, 0, 8'h20));
        wait_idle();
        issue(mk(1, 1, 1, 8'h99));
        chk("R10 accepted at once", 32'({host_rdata[25], lb_wr, lb_cs}), 32'b1_1_10);
        wait_idle();
        issue(mk(0, 1, 1, 8'h00)); wait_idle();
        chk("R10 data landed", 32'(host_rdata[7:0]), 32'h99);

        // Reset clears everything again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 after reset", host_rdata, 32'h0);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule